// File: doc/BRIEF.md
# Octet to 4-bit symbol mapper

This block sits between the packet assembler of a low-rate 2.4 GHz transmitter and its spreading stage. It receives the octets of a complete physical-layer packet (preamble, start delimiter, length, and a payload that closes with the frame check sequence) over a byte-wide valid/ready stream carrying a last marker. It cuts each octet into two 4-bit data symbols and passes them on over a symbol-wide valid/ready stream, also with a last marker.

One octet at a time is held. Its low nibble leaves first and its high nibble leaves second. Octets leave in the order they arrive, so every packet produces exactly twice as many symbols as it has octets. When the downstream stage stalls, the held symbol waits and nothing is lost or reordered. A new octet is taken in the same cycle that the high nibble of the previous octet is accepted downstream, so a stream with no stalls runs at one symbol per cycle.

Top module: `octet_symbol_mapper`

## Requirements
- R1: The first symbol sent for an octet is bits b0..b3 of that octet, with b0 as the symbol's least significant bit (`out_data = in_data[3:0]`).
- R2: The second symbol sent for an octet is bits b4..b7, with b4 as the symbol's least significant bit (`out_data = in_data[7:4]`).
- R3: Octets are converted strictly in arrival order, and each packet yields exactly two symbols per octet. An 11-octet packet therefore yields 22 symbols.
- R4: `out_last` is high only on the high-nibble symbol of the octet that arrived with `in_last` high. It is low on that octet's low-nibble symbol and on every symbol of any other octet.
- R5: `in_ready` is high when no octet is held, or when the held octet's high nibble is being accepted downstream in the same cycle. At all other times it is low, including the whole time the low nibble is pending.
- R6: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data` and `out_last` keep their values into the next cycle.
- R7: A synchronous active-high reset drops any held octet, even one that is half sent. After reset, `out_valid` is 0 and `in_ready` is 1, and the next octet accepted starts with its low nibble.
- R8: An octet accepted at a clock edge makes `out_valid` high in the following cycle. With `out_ready` held high and an octet always offered, a symbol is sent in every cycle with no gap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Octet offered |
| in_data | input | 8 | Octet value, bit 0 = b0 |
| in_last | input | 1 | Octet is the final one of its packet |
| in_ready | output | 1 | Octet taken at this edge when in_valid is high |
| out_valid | output | 1 | Symbol offered |
| out_data | output | 4 | Symbol value |
| out_last | output | 1 | Symbol is the final one of its packet |
| out_ready | input | 1 | Downstream takes the symbol at this edge |

## Verification
The hardest case to reach is a reset that arrives after the low nibble has left but before the high nibble has. The bench gets there by loading a single octet with downstream stalled, then releasing downstream for exactly one cycle and asserting reset right after. It then checks that the next octet starts cleanly with its low nibble. The other hard case is the same-edge hand-over, where a new octet is accepted just as the old high nibble is taken. Phases with both sides permanently willing make this happen on every octet, and phases with random valid and ready gaps make it happen only some of the time.

// File: rtl/osm_pkg.sv
package osm_pkg;

    localparam int OCTET_BITS        = 8;
    localparam int NIBBLE_BITS       = 4;
    localparam int NIBBLES_PER_OCTET = OCTET_BITS / NIBBLE_BITS;

    typedef enum logic {
        SLOT_IDLE = 1'b0,
        SLOT_HELD = 1'b1
    } slot_state_e;

    function automatic int slice_base(input int idx, input int width);
        return idx * width;
    endfunction

endpackage

// File: rtl/osm_slot.sv
module osm_slot #(
    parameter int WIDTH = osm_pkg::OCTET_BITS
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             drop,
    input  logic [WIDTH-1:0] din,
    input  logic             din_last,
    output logic             held,
    output logic [WIDTH-1:0] dout,
    output logic             dout_last
);
    import osm_pkg::*;

    slot_state_e state_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= SLOT_IDLE;
            dout      <= '0;
            dout_last <= 1'b0;
        end else if (load) begin
            state_q   <= SLOT_HELD;
            dout      <= din;
            dout_last <= din_last;
        end else if (drop) begin
            state_q   <= SLOT_IDLE;
        end
    end

    assign held = (state_q == SLOT_HELD);

endmodule

// File: rtl/osm_cursor.sv
module osm_cursor #(
    parameter int COUNT = osm_pkg::NIBBLES_PER_OCTET
) (
    input  logic clk,
    input  logic rst,
    input  logic advance,
    output logic [((COUNT > 1) ? $clog2(COUNT) : 1)-1:0] idx,
    output logic at_final
);
    localparam int IDX_W = (COUNT > 1) ? $clog2(COUNT) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(COUNT - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            idx <= '0;
        end else if (advance) begin
            if (at_final) idx <= '0;
            else          idx <= idx + 1'b1;
        end
    end

    assign at_final = (idx == LAST_IDX);

endmodule

// File: rtl/octet_symbol_mapper.sv
module octet_symbol_mapper #(
    parameter int SYM_W        = osm_pkg::NIBBLE_BITS,
    parameter int SYMS_PER_OCT = osm_pkg::NIBBLES_PER_OCTET
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          in_valid,
    input  logic [SYM_W*SYMS_PER_OCT-1:0] in_data,
    input  logic                          in_last,
    output logic                          in_ready,
    output logic                          out_valid,
    output logic [SYM_W-1:0]              out_data,
    output logic                          out_last,
    input  logic                          out_ready
);
    import osm_pkg::*;

    localparam int IN_W  = SYM_W * SYMS_PER_OCT;
    localparam int IDX_W = (SYMS_PER_OCT > 1) ? $clog2(SYMS_PER_OCT) : 1;

    logic             slot_held;
    logic [IN_W-1:0]  slot_data;
    logic             slot_last;
    logic [IDX_W-1:0] cur_idx;
    logic             at_final;
    logic             take;
    logic             drop;
    logic             load;

    assign take     = slot_held && out_ready;
    assign drop     = take && at_final;
    assign in_ready = !slot_held || drop;
    assign load     = in_valid && in_ready;

    osm_slot #(.WIDTH(IN_W)) u_slot (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .drop      (drop),
        .din       (in_data),
        .din_last  (in_last),
        .held      (slot_held),
        .dout      (slot_data),
        .dout_last (slot_last)
    );

    osm_cursor #(.COUNT(SYMS_PER_OCT)) u_cursor (
        .clk      (clk),
        .rst      (rst),
        .advance  (take),
        .idx      (cur_idx),
        .at_final (at_final)
    );

    assign out_valid = slot_held;
    assign out_data  = slot_data[slice_base(int'(cur_idx), SYM_W) +: SYM_W];
    assign out_last  = slot_last && at_final;

    // R6
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));

    // R5
    no_early_accept_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !at_final) |-> !in_ready);

    // R8
    accept_latency_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> out_valid);

    // R2
    high_follows_low_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready && !at_final) |=> out_valid);

    // R4
    last_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
        out_last |-> out_valid);

    // R7
    reset_empty_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!out_valid && in_ready));

endmodule

// File: tb/test_octet_symbol_mapper.sv
module test_octet_symbol_mapper;

    localparam int LIMIT = 100000;

    logic       clk = 1'b0;
    logic       rst;
    logic       in_valid;
    logic [7:0] in_data;
    logic       in_last;
    logic       in_ready;
    logic       out_valid;
    logic [3:0] out_data;
    logic       out_last;
    logic       out_ready;

    always #10 clk = ~clk;

    octet_symbol_mapper i_octet_symbol_mapper (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .in_last   (in_last),
        .in_ready  (in_ready),
        .out_valid (out_valid),
        .out_data  (out_data),
        .out_last  (out_last),
        .out_ready (out_ready)
    );

    typedef struct {
        logic [3:0] sym;
        logic       last;
        bit         hi;
    } exp_t;

    exp_t       exp_q[$];
    logic [8:0] src_q[$];
    int         pkt_len_q[$];
    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int sym_in_pkt = 0;
    int vprob = 100;
    int rprob = 100;
    bit timed_out = 0;
    bit prev_stall = 0;
    bit after_reset = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    task automatic step();
        string tag;
        @(negedge clk);
        cyc++;
        if (cyc > LIMIT && !timed_out) begin
            timed_out = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected below %0d", cyc, LIMIT);
        end
        in_valid  = (src_q.size() > 0) && ($urandom_range(99) < vprob);
        if (src_q.size() > 0) begin
            in_data = src_q[0][7:0];
            in_last = src_q[0][8];
        end else begin
            in_data = 8'($urandom);
            in_last = 1'b0;
        end
        out_ready = ($urandom_range(99) < rprob);
        #1;
        // R5: ready only when nothing held or the last held symbol leaves now
        check(in_ready == ((exp_q.size() == 0) || (exp_q.size() == 1 && out_ready)),
              "R5", "in_ready", int'(in_ready),
              int'((exp_q.size() == 0) || (exp_q.size() == 1 && out_ready)));
        // R8 / R6: a symbol is offered exactly while one is owed
        check(out_valid == (exp_q.size() > 0), prev_stall ? "R6" : "R8", "out_valid",
              int'(out_valid), int'(exp_q.size() > 0));
        if (out_valid && exp_q.size() > 0) begin
            if (prev_stall)       tag = "R6";
            else if (after_reset) tag = "R7";
            else if (exp_q[0].hi) tag = "R2";
            else                  tag = "R1";
            check(out_data == exp_q[0].sym, tag, "out_data", int'(out_data), int'(exp_q[0].sym));
            check(out_last == exp_q[0].last, "R4", "out_last", int'(out_last), int'(exp_q[0].last));
            if (out_ready) begin
                after_reset = 0;
                sym_in_pkt++;
                if (exp_q[0].last) begin
                    // R3: two symbols per octet of the packet
                    check(sym_in_pkt == 2 * pkt_len_q[0], "R3", "symbols in packet",
                          sym_in_pkt, 2 * pkt_len_q[0]);
                    void'(pkt_len_q.pop_front());
                    sym_in_pkt = 0;
                end
                void'(exp_q.pop_front());
            end
        end
        prev_stall = out_valid && !out_ready;
        if (in_valid && in_ready) begin
            exp_q.push_back('{sym: in_data[3:0], last: 1'b0,    hi: 1'b0});
            exp_q.push_back('{sym: in_data[7:4], last: in_last, hi: 1'b1});
            void'(src_q.pop_front());
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst       = 1'b1;
        in_valid  = 1'b0;
        out_ready = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        exp_q.delete();
        src_q.delete();
        pkt_len_q.delete();
        sym_in_pkt = 0;
        prev_stall = 0;
    endtask

    task automatic add_random_packet(input int len);
        for (int i = 0; i < len; i++)
            src_q.push_back({(i == len - 1) ? 1'b1 : 1'b0, 8'($urandom)});
        pkt_len_q.push_back(len);
    endtask

    task automatic add_ack_packet();
        logic [7:0] ack [11] = '{8'h00, 8'h00, 8'h00, 8'h00, 8'hA7, 8'h05,
                                  8'h02, 8'h00, 8'h5A, 8'h3C, 8'h91};
        for (int i = 0; i < 11; i++)
            src_q.push_back({(i == 10) ? 1'b1 : 1'b0, ack[i]});
        pkt_len_q.push_back(11);
    endtask

    task automatic drain();
        while ((src_q.size() > 0 || exp_q.size() > 0) && !timed_out) step();
    endtask

    initial begin
        rst = 1'b1; in_valid = 1'b0; in_data = '0; in_last = 1'b0; out_ready = 1'b0;
        do_reset();
        // R7: reset state seen at the ports
        vprob = 0; rprob = 0;
        step();
        check(out_valid == 1'b0, "R7", "out_valid after reset", int'(out_valid), 0);
        check(in_ready == 1'b1, "R7", "in_ready after reset", int'(in_ready), 1);

        // acknowledgement packet at full rate (R3, R8)
        vprob = 100; rprob = 100;
        add_ack_packet();
        drain();
        // same packet with heavy backpressure (R6)
        vprob = 100; rprob = 30;
        add_ack_packet();
        drain();

        // random packets under several valid/ready mixes
        for (int p = 0; p < 30 && !timed_out; p++) begin
            case (p % 4)
                0: begin vprob = 100; rprob = 100; end
                1: begin vprob = 70;  rprob = 40;  end
                2: begin vprob = 30;  rprob = 90;  end
                default: begin vprob = 90; rprob = 60; end
            endcase
            add_random_packet(1 + int'($urandom_range(19)));
            if (p % 3 == 0) add_random_packet(1 + int'($urandom_range(4)));
            drain();
        end

        // R7: reset between low and high nibble of one octet
        vprob = 100; rprob = 0;
        src_q.push_back({1'b1, 8'hB6});
        pkt_len_q.push_back(1);
        while (exp_q.size() < 2 && !timed_out) step();
        vprob = 0; rprob = 100;
        step();
        do_reset();
        vprob = 0; rprob = 0;
        step();
        check(out_valid == 1'b0, "R7", "out_valid after mid-octet reset", int'(out_valid), 0);
        check(in_ready == 1'b1, "R7", "in_ready after mid-octet reset", int'(in_ready), 1);
        after_reset = 1;
        vprob = 100; rprob = 100;
        src_q.push_back({1'b1, 8'h4D});
        pkt_len_q.push_back(1);
        drain();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule